// File: doc/BRIEF.md
# Clock divider search engine

This block looks for a usable integer divider for a functional clock that is produced by dividing a parent rate and then scaling it by a small multiplier. A search begins with a start pulse that carries five inputs: the parent rate, a multiplier select, the lowest rate the consumer will take, the highest rate the hardware can run at, and the largest divider the clock tree offers. The lowest rate sets how large the divider may get. The largest divider caps that value. The highest rate sets how small the divider may get.

The engine then walks the divider downward, one step at a time, from the upper bound to the lower bound. For each divider it offers the divider and the rate it produces to an external judge over a valid/ready handshake. The judge answers accept or reject. The first accept ends the search successfully and latches that divider. If every candidate is rejected, or if the range is empty, the search ends in failure.

Every division is done by one shared iterative restoring divider. A bypass mode also exists for a clock tree that has no programmable parent: the engine offers the current fixed rate once, with divider 1, and the judge's answer becomes the result.

Top module: `clkdiv_search`

## Requirements
- R1: After reset, the following are all 0: `busy_o`, `cand_valid_o`, `done_o`, `found_o` and `result_div_o`.
- R2: A minimum rate of 0 is treated as 1. The upper divider bound then becomes min(parent × multiplier, cap).
- R3: The first candidate offered is min(floor(parent × multiplier ÷ minimum rate), cap).
- R4: The lowest divider offered is max(1, ceil(parent × multiplier ÷ maximum rate)). A maximum rate of 0 is treated as 1. When a candidate at this bound is rejected, the search ends.
- R5: Each reject, unless it is the last one, is followed by a candidate whose divider is exactly one less than the rejected divider.
- R6: The candidate rate equals floor(parent ÷ divider) × multiplier. `mult_sel_i` = 0 selects ×1 and `mult_sel_i` = 1 selects ×2.
- R7: An accept ends the search. `done_o` pulses for one cycle, `found_o` = 1, `result_div_o` holds the accepted divider, `busy_o` returns to 0, and no further candidate is offered.
- R8: If the upper bound is below the lower bound, no candidate is offered. If every candidate is rejected, the search ends with `done_o`, `found_o` = 0 and `result_div_o` = 0.
- R9: The divider cap is selected by `div_cap_sel_i`: 0 selects 16, 1 selects 32, and 2 or 3 select 64. No candidate divider ever exceeds 64.
- R10: With `bypass_i` high at start, exactly one candidate is offered, with divider 1 and rate `cur_rate_i`. Accept gives `found_o` = 1 with `result_div_o` = 1. Reject gives `found_o` = 0 with `result_div_o` = 0.
- R11: While `cand_valid_o` is high and `cand_ready_i` is low, the candidate divider and rate hold steady and `cand_valid_o` stays high.
- R12: `start_i` has no effect while `busy_o` is high. The ongoing search keeps its latched inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a search (sampled when idle) |
| bypass_i | input | 1 | Offer the fixed current rate only |
| parent_rate_i | input | 32 | Parent clock rate |
| mult_sel_i | input | 1 | 0: ×1, 1: ×2 |
| min_rate_i | input | 32 | Lowest acceptable rate (0 means 1) |
| max_rate_i | input | 32 | Hardware maximum rate (0 means 1) |
| div_cap_sel_i | input | 2 | Divider cap: 16, 32, 64, 64 |
| cur_rate_i | input | 32 | Fixed current rate used in bypass |
| busy_o | output | 1 | Search in progress |
| cand_valid_o | output | 1 | Candidate offered |
| cand_ready_i | input | 1 | Judge has answered |
| cand_accept_i | input | 1 | Judge's answer: 1 accept, 0 reject |
| cand_div_o | output | 7 | Candidate divider |
| cand_rate_o | output | 33 | Candidate rate |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | Last search succeeded |
| result_div_o | output | 7 | Accepted divider, 0 on failure |

## Verification
The search is run with several patterns:
- A narrow range accepted part way down. This separates the upper bound from the first step.
- A wide ×2 range with a zero minimum, rejected to exhaustion. This shows the cap clamp and the final candidate at the lower bound.
- An empty range, where the minimum rate is above the parent rate.
- A single-candidate range at the largest cap.
- Accept on the very first candidate.

Bypass is tried with both an accept and a reject. Some runs hold the ready signal back for a cycle to expose unstable candidates. One run pulses start mid-search to show that the latched request survives.

// File: rtl/cds_pkg.sv
package cds_pkg;

    localparam int RATE_W = 32;
    localparam int DIV_W  = 7;
    localparam int PROD_W = RATE_W + 2;

    localparam logic [DIV_W-1:0] CAP_LO  = DIV_W'(16);
    localparam logic [DIV_W-1:0] CAP_MID = DIV_W'(32);
    localparam logic [DIV_W-1:0] CAP_HI  = DIV_W'(64);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QSTART,
        ST_QSTOP,
        ST_RATE,
        ST_OFFER
    } cds_state_e;

    typedef struct packed {
        logic [RATE_W-1:0] parent;
        logic              dbl;
        logic [RATE_W-1:0] min_eff;
        logic [RATE_W-1:0] hw_eff;
        logic [DIV_W-1:0]  cap;
        logic              bypass;
    } cds_req_t;

    function automatic logic [DIV_W-1:0] cap_decode(input logic [1:0] sel);
        case (sel)
            2'd0:    return CAP_LO;
            2'd1:    return CAP_MID;
            default: return CAP_HI;
        endcase
    endfunction

    function automatic logic [RATE_W-1:0] at_least_one(input logic [RATE_W-1:0] v);
        return (v == '0) ? RATE_W'(1) : v;
    endfunction

endpackage

// File: rtl/cds_udiv.sv
module cds_udiv #(
    parameter int N_W = 34,
    parameter int D_W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go_i,
    input  logic [N_W-1:0] dvd_i,
    input  logic [D_W-1:0] dsr_i,
    output logic           done_o,
    output logic [N_W-1:0] quo_o
);
    localparam int C_W = $clog2(N_W + 1);

    logic [N_W-1:0] sh_q, quo_q;
    logic [D_W-1:0] rem_q, dsr_q;
    logic [C_W-1:0] cnt_q;
    logic           run_q, done_q;
    logic [D_W:0]   trial, diff;
    logic           fits;

    always_comb begin
        trial = {rem_q, sh_q[N_W-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = trial >= {1'b0, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                sh_q  <= dvd_i;
                dsr_q <= dsr_i;
                rem_q <= '0;
                quo_q <= '0;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                sh_q  <= {sh_q[N_W-2:0], 1'b0};
                quo_q <= {quo_q[N_W-2:0], fits};
                rem_q <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
                cnt_q <= cnt_q + C_W'(1);
                if (cnt_q == C_W'(N_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;
endmodule

// File: rtl/cds_clamp.sv
module cds_clamp #(
    parameter int Q_W = 34,
    parameter int D_W = 7
) (
    input  logic [Q_W-1:0] quo_i,
    input  logic [D_W-1:0] cap_i,
    output logic [D_W-1:0] upper_o,
    output logic [D_W:0]   lower_o
);
    localparam logic [D_W:0] SAT = (D_W + 1)'(1) << D_W;

    always_comb begin
        // upper bound: never above the cap
        if (quo_i > Q_W'(cap_i)) upper_o = cap_i;
        else                     upper_o = quo_i[D_W-1:0];
        // lower bound: at least one, saturated beyond any legal divider
        if (quo_i == '0)               lower_o = (D_W + 1)'(1);
        else if (quo_i >= Q_W'(SAT))   lower_o = SAT;
        else                           lower_o = quo_i[D_W:0];
    end
endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import cds_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                bypass_i,
    input  logic [RATE_W-1:0]   parent_rate_i,
    input  logic                mult_sel_i,
    input  logic [RATE_W-1:0]   min_rate_i,
    input  logic [RATE_W-1:0]   max_rate_i,
    input  logic [1:0]          div_cap_sel_i,
    input  logic [RATE_W-1:0]   cur_rate_i,
    output logic                busy_o,
    output logic                cand_valid_o,
    input  logic                cand_ready_i,
    input  logic                cand_accept_i,
    output logic [DIV_W-1:0]    cand_div_o,
    output logic [RATE_W:0]     cand_rate_o,
    output logic                done_o,
    output logic                found_o,
    output logic [DIV_W-1:0]    result_div_o
);
    cds_state_e         st_q;
    cds_req_t           req_q;
    logic               go_q;
    logic [DIV_W-1:0]   div_q;
    logic [DIV_W:0]     stop_q;
    logic [RATE_W:0]    rate_q;
    logic               found_q, done_q;
    logic [DIV_W-1:0]   res_q;

    logic [PROD_W-1:0]  prod, dvd, quo;
    logic [RATE_W-1:0]  dsr;
    logic               udone;
    logic [DIV_W-1:0]   upper;
    logic [DIV_W:0]     lower;

    always_comb begin
        prod = req_q.dbl ? {1'b0, req_q.parent, 1'b0} : {2'b00, req_q.parent};
        case (st_q)
            ST_QSTART: begin
                dvd = prod;
                dsr = req_q.min_eff;
            end
            ST_QSTOP: begin
                // ceiling division: (a + b - 1) / b
                dvd = prod + PROD_W'(req_q.hw_eff) - PROD_W'(1);
                dsr = req_q.hw_eff;
            end
            default: begin
                dvd = PROD_W'(req_q.parent);
                dsr = RATE_W'(div_q);
            end
        endcase
    end

    cds_udiv #(.N_W(PROD_W), .D_W(RATE_W)) i_udiv (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go_q),
        .dvd_i  (dvd),
        .dsr_i  (dsr),
        .done_o (udone),
        .quo_o  (quo)
    );

    cds_clamp #(.Q_W(PROD_W), .D_W(DIV_W)) i_clamp (
        .quo_i   (quo),
        .cap_i   (req_q.cap),
        .upper_o (upper),
        .lower_o (lower)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            req_q   <= '0;
            go_q    <= 1'b0;
            div_q   <= '0;
            stop_q  <= '0;
            rate_q  <= '0;
            found_q <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q.parent  <= parent_rate_i;
                        req_q.dbl     <= mult_sel_i;
                        req_q.min_eff <= at_least_one(min_rate_i);
                        req_q.hw_eff  <= at_least_one(max_rate_i);
                        req_q.cap     <= cap_decode(div_cap_sel_i);
                        req_q.bypass  <= bypass_i;
                        found_q       <= 1'b0;
                        res_q         <= '0;
                        if (bypass_i) begin
                            div_q  <= DIV_W'(1);
                            rate_q <= {1'b0, cur_rate_i};
                            st_q   <= ST_OFFER;
                        end else begin
                            go_q <= 1'b1;
                            st_q <= ST_QSTART;
                        end
                    end
                end
                ST_QSTART: begin
                    if (udone) begin
                        div_q <= upper;
                        go_q  <= 1'b1;
                        st_q  <= ST_QSTOP;
                    end
                end
                ST_QSTOP: begin
                    if (udone) begin
                        stop_q <= lower;
                        if ({1'b0, div_q} < lower) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            go_q <= 1'b1;
                            st_q <= ST_RATE;
                        end
                    end
                end
                ST_RATE: begin
                    if (udone) begin
                        rate_q <= req_q.dbl ? {quo[RATE_W-1:0], 1'b0}
                                            : {1'b0, quo[RATE_W-1:0]};
                        st_q   <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (cand_ready_i) begin
                        if (cand_accept_i) begin
                            found_q <= 1'b1;
                            res_q   <= div_q;
                            done_q  <= 1'b1;
                            st_q    <= ST_IDLE;
                        end else if (req_q.bypass || ({1'b0, div_q} <= stop_q)) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            div_q <= div_q - DIV_W'(1);
                            go_q  <= 1'b1;
                            st_q  <= ST_RATE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (st_q != ST_IDLE);
    assign cand_valid_o = (st_q == ST_OFFER);
    assign cand_div_o   = div_q;
    assign cand_rate_o  = rate_q;
    assign done_o       = done_q;
    assign found_o      = found_q;
    assign result_div_o = res_q;
endmodule

// File: rtl/cds_checker.sv
module cds_checker
    import cds_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              cand_valid_o,
    input logic              cand_ready_i,
    input logic              cand_accept_i,
    input logic [DIV_W-1:0]  cand_div_o,
    input logic [RATE_W:0]   cand_rate_o,
    input logic              done_o,
    input logic              found_o,
    input logic [DIV_W-1:0]  result_div_o
);
    logic             pend_q;
    logic [DIV_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            last_q <= '0;
        end else if (done_o) begin
            pend_q <= 1'b0;
        end else if (cand_valid_o && cand_ready_i && !cand_accept_i) begin
            pend_q <= 1'b1;
            last_q <= cand_div_o;
        end else if (cand_valid_o) begin
            pend_q <= 1'b0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !cand_valid_o);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_o && pend_q) |-> (cand_div_o == last_q - DIV_W'(1)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_found_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && found_o) |-> (result_div_o != '0));

    assert_fail_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !found_o) |-> (result_div_o == '0));

    assert_div_range_R9: assert property (@(posedge clk) disable iff (rst)
        cand_valid_o |-> (cand_div_o != '0 && cand_div_o <= CAP_HI));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_o && !cand_ready_i) |=>
            (cand_valid_o && $stable(cand_div_o) && $stable(cand_rate_o)));
endmodule

bind clkdiv_search cds_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .cand_valid_o (cand_valid_o),
    .cand_ready_i (cand_ready_i),
    .cand_accept_i(cand_accept_i),
    .cand_div_o   (cand_div_o),
    .cand_rate_o  (cand_rate_o),
    .done_o       (done_o),
    .found_o      (found_o),
    .result_div_o (result_div_o)
);

// File: tb/test_clkdiv_search.sv
module test_clkdiv_search;
    import cds_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              bypass_i = 1'b0;
    logic [RATE_W-1:0] parent_rate_i = '0;
    logic              mult_sel_i = 1'b0;
    logic [RATE_W-1:0] min_rate_i = '0;
    logic [RATE_W-1:0] max_rate_i = '0;
    logic [1:0]        div_cap_sel_i = '0;
    logic [RATE_W-1:0] cur_rate_i = '0;
    logic              busy_o, cand_valid_o, done_o, found_o;
    logic              cand_ready_i = 1'b0;
    logic              cand_accept_i = 1'b0;
    logic [DIV_W-1:0]  cand_div_o, result_div_o;
    logic [RATE_W:0]   cand_rate_o;

    always #4 clk = ~clk;

    clkdiv_search i_clkdiv_search (
        .clk(clk), .rst(rst), .start_i(start_i), .bypass_i(bypass_i),
        .parent_rate_i(parent_rate_i), .mult_sel_i(mult_sel_i),
        .min_rate_i(min_rate_i), .max_rate_i(max_rate_i),
        .div_cap_sel_i(div_cap_sel_i), .cur_rate_i(cur_rate_i),
        .busy_o(busy_o), .cand_valid_o(cand_valid_o),
        .cand_ready_i(cand_ready_i), .cand_accept_i(cand_accept_i),
        .cand_div_o(cand_div_o), .cand_rate_o(cand_rate_o),
        .done_o(done_o), .found_o(found_o), .result_div_o(result_div_o)
    );

    typedef struct {
        longint unsigned div;
        longint unsigned rate;
    } exp_t;

    exp_t            exp_q[$];
    int              n_chk = 0;
    int              n_fail = 0;
    int              accept_at = -1;
    int              cand_idx = 0;
    bit              stall_en = 1'b0;
    bit              seen = 1'b0;
    bit              stalled = 1'b0;
    longint unsigned held_div, held_rate;

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected candidates and answers the handshake
    always @(negedge clk) begin
        if (!rst) begin
            if (cand_ready_i) begin
                cand_ready_i  = 1'b0;
                cand_accept_i = 1'b0;
                seen          = 1'b0;
                stalled       = 1'b0;
            end else if (cand_valid_o) begin
                if (!seen) begin
                    seen = 1'b1;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected candidate div", cand_div_o, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(cand_div_o == e.div, "R5", "candidate div", cand_div_o, e.div);
                        check(longint'(cand_rate_o) == e.rate, "R6", "candidate rate",
                              cand_rate_o, e.rate);
                    end
                    held_div  = cand_div_o;
                    held_rate = cand_rate_o;
                    cand_idx++;
                end else begin
                    check(cand_div_o == held_div && longint'(cand_rate_o) == held_rate,
                          "R11", "held candidate div", cand_div_o, held_div);
                end
                if (stall_en && !stalled) begin
                    stalled = 1'b1;
                end else begin
                    cand_ready_i  = 1'b1;
                    cand_accept_i = ((cand_idx - 1) == accept_at);
                end
            end
        end
    end

    task automatic run(input string tag, input longint unsigned par, input bit dbl,
                       input longint unsigned mn, input longint unsigned mx,
                       input int sel, input bit byp, input longint unsigned cur,
                       input int acc, input bit stall, input bit restart);
        longint unsigned m, prod, mne, hwe, cap, st, sp, q2;
        bit              exp_found;
        longint unsigned exp_res;
        int              idx;
        int              guard;
        exp_t            e;
        m   = dbl ? 2 : 1;
        exp_found = 1'b0;
        exp_res   = 0;
        idx = 0;
        if (byp) begin
            e.div = 1; e.rate = cur;
            exp_q.push_back(e);
            if (acc == 0) begin exp_found = 1'b1; exp_res = 1; end
        end else begin
            prod = par * m;
            mne  = (mn == 0) ? 1 : mn;
            hwe  = (mx == 0) ? 1 : mx;
            cap  = (sel == 0) ? 16 : (sel == 1) ? 32 : 64;
            st   = prod / mne;
            if (st > cap) st = cap;
            q2   = (prod + hwe - 1) / hwe;
            sp   = (q2 < 1) ? 1 : q2;
            for (longint d = longint'(st); d >= longint'(sp) && d >= 1; d--) begin
                e.div = longint'(d); e.rate = (par / longint'(d)) * m;
                exp_q.push_back(e);
                if (idx == acc) begin
                    exp_found = 1'b1; exp_res = longint'(d);
                    break;
                end
                idx++;
            end
        end
        accept_at = acc;
        cand_idx  = 0;
        stall_en  = stall;
        @(negedge clk);
        parent_rate_i = par[RATE_W-1:0];
        mult_sel_i    = dbl;
        min_rate_i    = mn[RATE_W-1:0];
        max_rate_i    = mx[RATE_W-1:0];
        div_cap_sel_i = sel[1:0];
        bypass_i      = byp;
        cur_rate_i    = cur[RATE_W-1:0];
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (restart) begin
            repeat (5) @(negedge clk);
            parent_rate_i = 7;
            min_rate_i    = 1;
            start_i       = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (!done_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done_o == 1'b1, tag, "done seen", done_o, 1);
        check(found_o == exp_found, tag, "found", found_o, exp_found);
        check(result_div_o == exp_res, tag, "result divider", result_div_o, exp_res);
        check(busy_o == 1'b0, "R7", "busy after done", busy_o, 0);
        check(exp_q.size() == 0, restart ? "R12" : tag, "unoffered candidates",
              exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(done_o == 1'b0, "R7", "done is a pulse", done_o, 0);
        check(cand_valid_o == 1'b0, "R7", "no candidate after end", cand_valid_o, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy", busy_o, 0);
        check(cand_valid_o == 1'b0, "R1", "valid", cand_valid_o, 0);
        check(done_o == 1'b0, "R1", "done", done_o, 0);
        check(found_o == 1'b0, "R1", "found", found_o, 0);
        check(result_div_o == '0, "R1", "result", result_div_o, 0);

        // R3: start 10, stop 3, third candidate accepted, with stalls and a restart (R12)
        run("R3", 1000, 1'b0, 100, 400, 0, 1'b0, 0, 2, 1'b1, 1'b1);
        // R2 and R6: zero minimum, x2, cap 32, exhausted down to 2
        run("R2", 1000, 1'b1, 0, 1000, 1, 1'b0, 0, -1, 1'b0, 1'b0);
        // R8: empty range (minimum above parent)
        run("R8", 100, 1'b0, 200, 50, 0, 1'b0, 0, 0, 1'b0, 1'b0);
        // R9: cap 64 with first candidate accepted
        run("R9", 5000, 1'b0, 10, 5000, 2, 1'b0, 0, 0, 1'b0, 1'b0);
        // R4: cap select 3, single candidate at the stop bound, rejected
        run("R4", 640, 1'b1, 1, 20, 3, 1'b0, 0, -1, 1'b1, 1'b0);
        // R10: bypass accepted, then rejected
        run("R10", 0, 1'b0, 0, 0, 0, 1'b1, 12345, 0, 1'b1, 1'b0);
        run("R10", 0, 1'b0, 0, 0, 0, 1'b1, 777, -1, 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule